// File: doc/BRIEF.md
# Ethernet Receive Statistics Counters

This block keeps three receive statistics for an Ethernet MAC: frames longer than a programmable limit, frames that end with a partial byte, and frames sent to a group address. The receive path presents one status beat at the end of every frame. The beat carries the frame's length in whole bytes, counted from the destination address through the FCS. It also carries a flag for a trailing partial byte and the 48-bit destination address. The block sorts the beat into counter increments in the same cycle it arrives.

The status input is a one-cycle valid strobe and has no ready signal. The block accepts a beat on every cycle that `fr_valid` is high, so it never applies back-pressure, and the receive path may send beats on consecutive cycles. A small register bus gives software access to the counters and the length limit. Software reads each counter, clears a counter by writing any value to its address, and programs the 16-bit length limit. The counters saturate rather than wrap.

Top module: `ethrx_stat_counters`

## Requirements
- R1: After reset every counter reads 0 and the length limit reads 1518.
- R2: A valid beat with no partial byte and a length strictly greater than the limit adds one to the oversize counter. A length equal to the limit does not count.
- R3: A valid beat with `fr_resid` high adds one to the residual counter and never adds to the oversize counter, whatever its length.
- R4: A valid beat adds one to the multicast counter when bit 0 of the first destination octet (`fr_dst[7:0]`) is 1. The all-ones broadcast address is excluded.
- R5: A counter at its all-ones value stays there on further increments until it is cleared.
- R6: A write of any data to a counter's address sets that counter to 0 on the next clock.
- R7: When a clear and an increment hit the same counter in the same cycle, the counter becomes 0.
- R8: A write to address 0 loads `reg_wdata[15:0]` into the length limit. Bits above 15 are ignored, and a read of address 0 returns the limit zero-extended.
- R9: The address map is 0 for the length limit, 1 for oversize, 2 for residual and 3 for multicast. Read data appears on `reg_rdata` one clock after `reg_re`, and a read changes no state.
- R10: While `fr_valid` is low, no counter changes, whatever the other status inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fr_valid | input | 1 | End-of-frame status strobe, one cycle per frame |
| fr_len | input | 16 | Frame length in bytes |
| fr_resid | input | 1 | Frame ended with a partial byte |
| fr_dst | input | 48 | Destination address, first octet in bits 7:0 |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |

## Verification
The bench probes the length boundary from both sides. A design that used greater-or-equal would count a frame of exactly the limit, and one that ignored the upper write bits would load the wrong limit. Two kinds of frame are sent that a loose design would miscount: an oversize frame with a partial byte, which a design without the exclusion would count twice, and a broadcast frame, which a design testing only the group bit would count as multicast. The bench also places a clear and an increment on the same counter in the same cycle, where a design that gave priority to the increment would read 1. A second instance with 4-bit counters receives more frames than its counters can hold, so a wrapping design would read a small value there instead of 15.

// File: rtl/ethrx_stat_pkg.sv
package ethrx_stat_pkg;
  localparam int unsigned NUM_CNT = 3;

  // Counter slots; the register address of slot k is k + 1.
  localparam int unsigned SLOT_OVER  = 0;
  localparam int unsigned SLOT_RESID = 1;
  localparam int unsigned SLOT_MCAST = 2;

  typedef enum logic [1:0] {
    RA_MAXLEN = 2'd0,
    RA_OVER   = 2'd1,
    RA_RESID  = 2'd2,
    RA_MCAST  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/ethrx_frame_classify.sv
module ethrx_frame_classify
  import ethrx_stat_pkg::*;
#(
  parameter int unsigned LEN_W = 16,
  parameter int unsigned MAC_W = 48
) (
  input  logic                  fr_valid,
  input  logic [LEN_W-1:0]      fr_len,
  input  logic                  fr_resid,
  input  logic [MAC_W-1:0]      fr_dst,
  input  logic [LEN_W-1:0]      max_len,
  output logic [NUM_CNT-1:0]    hit
);
  logic too_long;
  logic group_bit;
  logic is_bcast;

  always_comb begin
    too_long  = fr_len > max_len;
    group_bit = fr_dst[0];
    is_bcast  = &fr_dst;
    hit                 = '0;
    hit[SLOT_OVER]      = fr_valid && too_long && !fr_resid;
    hit[SLOT_RESID]     = fr_valid && fr_resid;
    hit[SLOT_MCAST]     = fr_valid && group_bit && !is_bcast;
  end
endmodule

// File: rtl/ethrx_sat_counter.sv
module ethrx_sat_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic at_max;
  assign at_max = cnt == CNT_MAX;

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt <= '0;
    else if (clr)             cnt <= '0;
    else if (inc && !at_max)  cnt <= cnt + 1'b1;
  end

  AST_CLEAR_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt == '0);  // R6
  AST_CLEAR_BEATS_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && inc) |=> cnt == '0);  // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_MAX && !clr) |=> cnt == CNT_MAX);  // R5
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !clr) |=> $stable(cnt));  // R10
endmodule

// File: rtl/ethrx_reg_if.sv
module ethrx_reg_if
  import ethrx_stat_pkg::*;
#(
  parameter int unsigned LEN_W      = 16,
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned BUS_W      = 32,
  parameter int unsigned ADDR_W     = 2,
  parameter int unsigned MAXLEN_RST = 1518
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           reg_we,
  input  logic                           reg_re,
  input  logic [ADDR_W-1:0]              reg_addr,
  input  logic [BUS_W-1:0]               reg_wdata,
  input  logic [NUM_CNT-1:0][CNT_W-1:0]  cnt_vals,
  output logic [NUM_CNT-1:0]             cnt_clr,
  output logic [LEN_W-1:0]               max_len,
  output logic [BUS_W-1:0]               reg_rdata
);
  logic [BUS_W-1:0] rd_mux;
  logic             unused_wdata_hi;

  assign unused_wdata_hi = ^reg_wdata[BUS_W-1:LEN_W];

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_clr
    assign cnt_clr[k] = reg_we && (reg_addr == ADDR_W'(k + 1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      max_len <= LEN_W'(MAXLEN_RST);
    else if (reg_we && reg_addr == ADDR_W'(RA_MAXLEN))
      max_len <= reg_wdata[LEN_W-1:0];
  end

  always_comb begin
    rd_mux = BUS_W'(max_len);
    for (int k = 0; k < NUM_CNT; k++)
      if (reg_addr == ADDR_W'(k + 1)) rd_mux = BUS_W'(cnt_vals[k]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_re) reg_rdata <= rd_mux;
  end

  AST_LIMIT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == ADDR_W'(RA_MAXLEN)) |=> max_len == $past(reg_wdata[LEN_W-1:0]));  // R8
  AST_LIMIT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_addr == ADDR_W'(RA_MAXLEN)) |=> $stable(max_len));  // R9
  AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cnt_clr));  // R6
endmodule

// File: rtl/ethrx_stat_counters.sv
module ethrx_stat_counters
  import ethrx_stat_pkg::*;
#(
  parameter int unsigned LEN_W      = 16,
  parameter int unsigned MAC_W      = 48,
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned BUS_W      = 32,
  parameter int unsigned MAXLEN_RST = 1518
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fr_valid,
  input  logic [LEN_W-1:0]  fr_len,
  input  logic              fr_resid,
  input  logic [MAC_W-1:0]  fr_dst,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [1:0]        reg_addr,
  input  logic [BUS_W-1:0]  reg_wdata,
  output logic [BUS_W-1:0]  reg_rdata
);
  localparam int unsigned ADDR_W = $clog2(NUM_CNT + 1);

  logic [NUM_CNT-1:0]            hit;
  logic [NUM_CNT-1:0]            clr;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_vals;
  logic [LEN_W-1:0]              max_len;

  ethrx_frame_classify #(.LEN_W(LEN_W), .MAC_W(MAC_W)) u_classify (
    .fr_valid (fr_valid),
    .fr_len   (fr_len),
    .fr_resid (fr_resid),
    .fr_dst   (fr_dst),
    .max_len  (max_len),
    .hit      (hit)
  );

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
    ethrx_sat_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (hit[k]),
      .clr   (clr[k]),
      .cnt   (cnt_vals[k])
    );
  end

  ethrx_reg_if #(
    .LEN_W(LEN_W), .CNT_W(CNT_W), .BUS_W(BUS_W),
    .ADDR_W(ADDR_W), .MAXLEN_RST(MAXLEN_RST)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_re    (reg_re),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .cnt_vals  (cnt_vals),
    .cnt_clr   (clr),
    .max_len   (max_len),
    .reg_rdata (reg_rdata)
  );

  AST_RESID_NOT_OVERSIZE: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_valid && fr_resid) |-> !hit[SLOT_OVER]);  // R3
  AST_RESID_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_valid && fr_resid) |-> hit[SLOT_RESID]);  // R3
  AST_BCAST_NOT_MCAST: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_valid && &fr_dst) |-> !hit[SLOT_MCAST]);  // R4
  AST_IDLE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !fr_valid |-> hit == '0);  // R10
  AST_READ_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_re && !reg_we && !fr_valid) |=> $stable(cnt_vals));  // R9
endmodule

// File: tb/ethrx_stat_counters_tb.sv
module ethrx_stat_counters_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fr_valid = 1'b0;
  logic [15:0] fr_len = '0;
  logic        fr_resid = 1'b0;
  logic [47:0] fr_dst = '0;
  logic        reg_we = 1'b0;
  logic        reg_re = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] rdata_s;

  int errors = 0;
  int checks = 0;
  int exp_over = 0, exp_resid = 0, exp_mc = 0;
  logic [31:0] rv;

  always #5 clk = ~clk;

  ethrx_stat_counters dut_i (
    .clk(clk), .rst_n(rst_n), .fr_valid(fr_valid), .fr_len(fr_len),
    .fr_resid(fr_resid), .fr_dst(fr_dst), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  ethrx_stat_counters #(.CNT_W(4)) dut_s (
    .clk(clk), .rst_n(rst_n), .fr_valid(fr_valid), .fr_len(fr_len),
    .fr_resid(fr_resid), .fr_dst(fr_dst), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata_s)
  );

  localparam logic [47:0] UNI = 48'h0000_0000_0002;
  localparam logic [47:0] MC  = 48'h0000_5E00_0001;
  localparam logic [47:0] BC  = 48'hFFFF_FFFF_FFFF;

  // {len[15:0], resid, dst[47:0], add_over, add_resid, add_mcast}
  localparam logic [67:0] VEC [8] = '{
    {16'd64,   1'b0, UNI, 3'b000},
    {16'd1518, 1'b0, UNI, 3'b000},
    {16'd1519, 1'b0, UNI, 3'b100},
    {16'd2000, 1'b1, UNI, 3'b010},
    {16'd100,  1'b1, MC,  3'b011},
    {16'd1600, 1'b0, MC,  3'b101},
    {16'd1600, 1'b0, BC,  3'b100},
    {16'd60,   1'b0, BC,  3'b000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_frame(input logic [15:0] len, input logic resid, input logic [47:0] dst);
    @(negedge clk);
    fr_valid = 1'b1; fr_len = len; fr_resid = resid; fr_dst = dst;
    @(negedge clk);
    fr_valid = 1'b0;
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_re = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_re = 1'b0;
    v = reg_rdata;
  endtask

  task automatic check_all(input string req);
    reg_read(2'd1, rv); check({req, " oversize"}, rv, exp_over);
    reg_read(2'd2, rv); check({req, " residual"}, rv, exp_resid);
    reg_read(2'd3, rv); check({req, " multicast"}, rv, exp_mc);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check_all("R1");
    reg_read(2'd0, rv); check("R1 limit", rv, 32'd1518);

    // Table walk: R2, R3, R4
    for (int i = 0; i < 8; i++) begin
      send_frame(VEC[i][67:52], VEC[i][51], VEC[i][50:3]);
      exp_over  += int'(VEC[i][2]);
      exp_resid += int'(VEC[i][1]);
      exp_mc    += int'(VEC[i][0]);
      check_all($sformatf("R2/R3/R4 vec%0d", i));
    end

    // R9 repeated reads change nothing
    reg_read(2'd1, rv); check("R9 reread", rv, exp_over);
    reg_read(2'd1, rv); check("R9 reread", rv, exp_over);

    // R8 limit write with upper bits set
    reg_write(2'd0, 32'hABCD_0040);
    reg_read(2'd0, rv); check("R8 limit", rv, 32'h40);
    send_frame(16'h40, 1'b0, UNI);
    send_frame(16'h41, 1'b0, UNI); exp_over++;
    check_all("R8 boundary");

    // R10 idle inputs ignored
    @(negedge clk);
    fr_len = 16'hFFFF; fr_resid = 1'b1; fr_dst = MC;
    repeat (3) @(negedge clk);
    check_all("R10");

    // R6 clear by any write
    reg_write(2'd1, 32'h1234_5678); exp_over = 0;
    reg_write(2'd2, 32'h0);         exp_resid = 0;
    check_all("R6");

    // R7 clear and increment in the same cycle
    @(negedge clk);
    fr_valid = 1'b1; fr_len = 16'd2000; fr_resid = 1'b0; fr_dst = MC;
    reg_we = 1'b1; reg_addr = 2'd1; reg_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    fr_valid = 1'b0; reg_we = 1'b0;
    exp_mc++;
    check_all("R7");

    // R5 saturation on the narrow instance
    reg_write(2'd3, 32'h5);
    for (int n = 0; n < 20; n++) send_frame(16'd64, 1'b0, MC);
    reg_read(2'd3, rv);
    check("R5 wide", rv, 32'd20);
    check("R5 narrow", rdata_s, 32'd15);
    reg_write(2'd3, 32'h1);
    reg_read(2'd3, rv);
    check("R6 narrow clear", rdata_s, 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule